// File: doc/BRIEF.md
# Hint-Guided Cache Victim Selector

This block holds the tag, valid, eviction-preference and recency state for every set of a set-associative cache and decides, for each incoming load, whether it hits and which way it uses. Each request names a set and a tag and carries one hint bit from software. The hint says whether the data is worth keeping: when it is set, the line becomes a preferred candidate for the next eviction in that set.

On a hit the matching way becomes the most recently used line, and its preference flag takes the hint of the current request. On a miss the block picks a victim in a fixed order. An empty way comes first. Next comes a valid line whose flag is set; among several flagged lines the least recently used one is taken. Only when no line is flagged does the plain least-recently-used way go. The new tag is then installed in that way as valid, most recently used, and flagged with the request's hint. Data storage and refill timing are the surrounding cache's job. The associativity and set count are parameters, so the same block serves a small first-level array or a larger second-level one.

Each request is answered one cycle later, and a new request is accepted every cycle. Two back-to-back requests to the same set see each other's updates.

Top module: `hint_repl_ctrl`

## Requirements
- R1: After reset every way of every set is empty and `rsp_valid` is 0. The first miss to any set fills way 0.
- R2: A request with `req_valid`=1 at a rising edge produces `rsp_valid`=1 for exactly the following cycle. Requests may arrive on consecutive cycles, and each one sees the state left by the one before it.
- R3: A request hits when a valid way in the indexed set holds the requested tag. On a hit, `rsp_hit`=1, `rsp_way` gives that way and `rsp_victim` is 0. On a miss, `rsp_hit`=0 and `rsp_way` is 0.
- R4: On a miss in a set that still has an empty way, the victim is the lowest-numbered empty way, even if a valid line in the set is flagged.
- R5: On a miss in a full set with no flagged line, the victim is the least recently used way. Recency is kept as a distinct age per way: 0 is the most recent and WAYS-1 the oldest. The evicted tag misses afterwards.
- R6: On a miss in a full set, a flagged line is chosen before any unflagged line, even when the flagged line is the most recently used.
- R7: When several lines in a full set are flagged, the victim is the least recently used of the flagged lines.
- R8: On a hit the line becomes most recently used, and its flag is overwritten with the request's hint: a hint of 0 clears an earlier flag.
- R9: On a miss the victim way is loaded with the request's tag, marked valid, made most recently used, and flagged with the request's hint.
- R10: Sets are independent. A request only reads and changes the state of the set it names.
- R11: A cycle with `req_valid`=0 changes no state and gives `rsp_valid`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_index | input | IDX_W | Set index |
| req_tag | input | TAG_W | Tag of the requested line |
| req_hint | input | 1 | 1 = mark the line as a preferred eviction candidate |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | WAY_W | Way that hit (0 on a miss) |
| rsp_victim | output | WAY_W | Way chosen and refilled on a miss (0 on a hit) |

## Verification
The bench drives one set through a full life cycle, and each step targets a priority rule. A design that ranked flags above empty ways would evict a valid line while a way was still free. A victim logic that ignored flags would throw out a stale LRU line in place of a flagged line that was just used. Picking the first flagged way instead of the oldest would choose the wrong way when two lines are flagged. A hit that only ever set the flag and never cleared it would keep evicting a line that software had since marked as worth keeping. Further requests check that a fill takes the hint, that a second set is untouched, that idle cycles change nothing, and that back-to-back requests to one set see each other's updates.

// File: rtl/hint_repl_pkg.sv
package hint_repl_pkg;

  // Which rule chose the victim on a miss; ordered by priority.
  typedef enum logic [1:0] {
    SRC_EMPTY   = 2'd0,
    SRC_FLAGGED = 2'd1,
    SRC_OLDEST  = 2'd2
  } victim_src_e;

endpackage

// File: rtl/hint_repl_lookup.sv
module hint_repl_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            look_tag,
  output logic [WAYS-1:0]             match_vec,
  output logic                        any_match,
  output logic [WAY_W-1:0]            match_way
);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
  end

  assign any_match = |match_vec;

  always_comb begin
    match_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_vec[w]) begin
        match_way = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/hint_repl_victim.sv
module hint_repl_victim
  import hint_repl_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0]             way_flag,
  input  logic [WAYS-1:0][WAY_W-1:0]  way_age,
  output logic [WAY_W-1:0]            victim_way,
  output victim_src_e                 victim_src
);

  localparam logic [WAY_W-1:0] OLDEST_AGE = WAY_W'(WAYS - 1);

  logic               have_empty;
  logic [WAY_W-1:0]   empty_way;
  logic               have_flagged;
  logic [WAY_W-1:0]   flagged_way;
  logic [WAY_W-1:0]   flagged_age;
  logic [WAY_W-1:0]   oldest_way;

  // Lowest-numbered empty way.
  always_comb begin
    have_empty = 1'b0;
    empty_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        have_empty = 1'b1;
        empty_way  = WAY_W'(w);
      end
    end
  end

  // Oldest among valid flagged ways.
  always_comb begin
    have_flagged = 1'b0;
    flagged_way  = '0;
    flagged_age  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_valid[w] && way_flag[w] &&
          (!have_flagged || (way_age[w] > flagged_age))) begin
        have_flagged = 1'b1;
        flagged_way  = WAY_W'(w);
        flagged_age  = way_age[w];
      end
    end
  end

  // Plain least recently used way.
  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_age[w] == OLDEST_AGE) begin
        oldest_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (have_empty) begin
      victim_way = empty_way;
      victim_src = SRC_EMPTY;
    end else if (have_flagged) begin
      victim_way = flagged_way;
      victim_src = SRC_FLAGGED;
    end else begin
      victim_way = oldest_way;
      victim_src = SRC_OLDEST;
    end
  end

endmodule

// File: rtl/hint_repl_age.sv
module hint_repl_age #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0]  age_cur,
  input  logic [WAY_W-1:0]            touch_way,
  output logic [WAYS-1:0][WAY_W-1:0]  age_nxt
);

  logic [WAY_W-1:0] touch_age;

  assign touch_age = age_cur[touch_way];

  // Touched way goes to age 0; every way younger than it ages by one.
  for (genvar g = 0; g < WAYS; g++) begin : g_age
    always_comb begin
      if (touch_way == WAY_W'(g)) begin
        age_nxt[g] = '0;
      end else if (age_cur[g] < touch_age) begin
        age_nxt[g] = age_cur[g] + 1'b1;
      end else begin
        age_nxt[g] = age_cur[g];
      end
    end
  end

endmodule

// File: rtl/hint_repl_ctrl.sv
module hint_repl_ctrl
  import hint_repl_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_hint,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [WAY_W-1:0]  rsp_victim
);

  // State arrays
  logic [WAYS-1:0]                valid_q [SETS];
  logic [WAYS-1:0]                flag_q  [SETS];
  logic [WAYS-1:0][WAY_W-1:0]     age_q   [SETS];
  logic [WAYS-1:0][TAG_W-1:0]     tag_q   [SETS];

  // Indexed set view
  logic [WAYS-1:0]                set_valid;
  logic [WAYS-1:0]                set_flag;
  logic [WAYS-1:0][WAY_W-1:0]     set_age;
  logic [WAYS-1:0][TAG_W-1:0]     set_tag;

  logic [WAYS-1:0]                hit_vec;
  logic                           hit;
  logic [WAY_W-1:0]               hit_way;
  logic [WAY_W-1:0]               victim_way;
  victim_src_e                    victim_src;
  logic [WAY_W-1:0]               touch_way;
  logic [WAYS-1:0][WAY_W-1:0]     age_upd;

  // Next-state of the indexed set
  logic [WAYS-1:0]                valid_d;
  logic [WAYS-1:0]                flag_d;
  logic                           state_en;
  logic                           tag_en;

  // Response next-state
  logic                           rsp_valid_d;
  logic                           rsp_hit_d;
  logic [WAY_W-1:0]               rsp_way_d;
  logic [WAY_W-1:0]               rsp_victim_d;

  always_comb begin
    set_valid = valid_q[req_index];
    set_flag  = flag_q[req_index];
    set_age   = age_q[req_index];
    set_tag   = tag_q[req_index];
  end

  hint_repl_lookup #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W)
  ) lookup_i (
    .way_valid (set_valid),
    .way_tag   (set_tag),
    .look_tag  (req_tag),
    .match_vec (hit_vec),
    .any_match (hit),
    .match_way (hit_way)
  );

  hint_repl_victim #(
    .WAYS (WAYS)
  ) victim_i (
    .way_valid  (set_valid),
    .way_flag   (set_flag),
    .way_age    (set_age),
    .victim_way (victim_way),
    .victim_src (victim_src)
  );

  assign touch_way = hit ? hit_way : victim_way;

  hint_repl_age #(
    .WAYS (WAYS)
  ) age_i (
    .age_cur   (set_age),
    .touch_way (touch_way),
    .age_nxt   (age_upd)
  );

  // Set state next-state
  always_comb begin
    state_en = req_valid;
    tag_en   = req_valid && !hit;
    valid_d  = set_valid;
    flag_d   = set_flag;
    valid_d[touch_way] = 1'b1;
    flag_d[touch_way]  = req_hint;
  end

  // Response next-state
  always_comb begin
    rsp_valid_d  = req_valid;
    rsp_hit_d    = req_valid && hit;
    rsp_way_d    = '0;
    rsp_victim_d = '0;
    if (req_valid) begin
      if (hit) begin
        rsp_way_d = hit_way;
      end else begin
        rsp_victim_d = victim_way;
      end
    end
  end

  // Set state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        flag_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (state_en) begin
      valid_q[req_index] <= valid_d;
      flag_q[req_index]  <= flag_d;
      age_q[req_index]   <= age_upd;
    end
  end

  // Tag storage: no reset needed, qualified by valid
  always_ff @(posedge clk) begin
    if (tag_en) begin
      tag_q[req_index][victim_way] <= req_tag;
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_victim <= '0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_hit    <= rsp_hit_d;
      rsp_way    <= rsp_way_d;
      rsp_victim <= rsp_victim_d;
    end
  end

endmodule

// File: rtl/hint_repl_checker.sv
module hint_repl_checker
  import hint_repl_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        rsp_valid,
  input  logic                        rsp_hit,
  input  logic [WAY_W-1:0]            rsp_way,
  input  logic [WAY_W-1:0]            rsp_victim,
  input  logic [WAYS-1:0]             set_valid,
  input  logic [WAYS-1:0]             set_flag,
  input  logic [WAYS-1:0][WAY_W-1:0]  set_age,
  input  logic [WAYS-1:0]             hit_vec,
  input  logic [WAY_W-1:0]            victim_way,
  input  victim_src_e                 victim_src
);

  logic [WAYS-1:0] age_seen;
  logic            miss_now;

  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) begin
      age_seen[set_age[w]] = 1'b1;
    end
  end

  assign miss_now = req_valid && !(|hit_vec);

  AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R11

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3

  AST_HIT_NO_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_victim == '0)); // R3

  AST_MISS_NO_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_way == '0)); // R3

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_now && !(&set_valid)) |-> !set_valid[victim_way]); // R4

  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    &age_seen); // R5

  AST_OLDEST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_now && (&set_valid) && !(|set_flag))
      |-> (set_age[victim_way] == WAY_W'(WAYS - 1))); // R5

  AST_FLAG_PREFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_now && (&set_valid) && (|set_flag))
      |-> (set_flag[victim_way] && (victim_src == SRC_FLAGGED))); // R6

endmodule

bind hint_repl_ctrl hint_repl_checker #(
  .WAYS (WAYS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_way    (rsp_way),
  .rsp_victim (rsp_victim),
  .set_valid  (set_valid),
  .set_flag   (set_flag),
  .set_age    (set_age),
  .hit_vec    (hit_vec),
  .victim_way (victim_way),
  .victim_src (victim_src)
);

// File: tb/hint_repl_ctrl_tb.sv
module hint_repl_ctrl_tb_top;

  localparam int WAYS  = 4;
  localparam int SETS  = 16;
  localparam int TAG_W = 12;
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(SETS);

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [IDX_W-1:0]  req_index;
  logic [TAG_W-1:0]  req_tag;
  logic              req_hint;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [WAY_W-1:0]  rsp_way;
  logic [WAY_W-1:0]  rsp_victim;

  typedef struct {
    logic             hit;
    logic [WAY_W-1:0] way;
    logic [WAY_W-1:0] vic;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks;
  int   n_fails;
  bit   done;

  hint_repl_ctrl #(
    .WAYS  (WAYS),
    .SETS  (SETS),
    .TAG_W (TAG_W)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_index  (req_index),
    .req_tag    (req_tag),
    .req_hint   (req_hint),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_victim (rsp_victim)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: compare each response with the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R2: unexpected response hit=%0b way=%0d vic=%0d, expected none",
                 rsp_hit, rsp_way, rsp_victim);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_hit !== e.hit || rsp_way !== e.way || rsp_victim !== e.vic) begin
          n_fails++;
          $display("FAIL %s: hit=%0b way=%0d vic=%0d, expected hit=%0b way=%0d vic=%0d",
                   e.req, rsp_hit, rsp_way, rsp_victim, e.hit, e.way, e.vic);
        end
      end
    end
  end

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic send(input logic [IDX_W-1:0] idx, input logic [TAG_W-1:0] tag,
                      input logic hint, input logic eh, input logic [WAY_W-1:0] ew,
                      input logic [WAY_W-1:0] ev, input string req);
    exp_t e;
    e.hit = eh; e.way = ew; e.vic = ev; e.req = req;
    exp_q.push_back(e);
    req_valid = 1'b1;
    req_index = idx;
    req_tag   = tag;
    req_hint  = hint;
    @(negedge clk);
  endtask

  task automatic idle_check(input string req);
    req_valid = 1'b0;
    req_tag   = '1;
    req_hint  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL %s: rsp_valid=%0b, expected 0", req, rsp_valid);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    req_valid = 1'b0; req_index = '0; req_tag = '0; req_hint = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fails++; $display("FAIL R1: rsp_valid=%0b in reset, expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fails++; $display("FAIL R1: rsp_valid=%0b after reset, expected 0", rsp_valid);
    end

    // Fill set 3 back to back (R1, R4, R9, R2)
    send(4'd3, 12'd10, 1'b0, 1'b0, 2'd0, 2'd0, "R1");
    send(4'd3, 12'd11, 1'b0, 1'b0, 2'd0, 2'd1, "R4");
    send(4'd3, 12'd12, 1'b1, 1'b0, 2'd0, 2'd2, "R4");
    // way 2 is flagged but way 3 is still empty: empty wins (R4)
    send(4'd3, 12'd13, 1'b0, 1'b0, 2'd0, 2'd3, "R4");
    // clear flag on way 2 by a hit with hint 0 (R8); ages way2=0,3=1,1=2,0=3
    send(4'd3, 12'd12, 1'b0, 1'b1, 2'd2, 2'd0, "R8");
    // hit way 0 (R3); ages 0=0,2=1,3=2,1=3
    send(4'd3, 12'd10, 1'b0, 1'b1, 2'd0, 2'd0, "R3");
    // no flags: evict LRU way 1 (R5); ages 1=0,0=1,2=2,3=3
    send(4'd3, 12'd20, 1'b0, 1'b0, 2'd0, 2'd1, "R5");
    send(4'd3, 12'd11, 1'b0, 1'b0, 2'd0, 2'd3, "R5"); // evicted tag misses, LRU way3
    // ages 3=0,1=1,0=2,2=3. Flag way 1 via hit (R8); ages 1=0,3=1,0=2,2=3
    send(4'd3, 12'd20, 1'b1, 1'b1, 2'd1, 2'd0, "R8");
    // flagged MRU way 1 is chosen over LRU way 2 (R6); new line unflagged (R9)
    send(4'd3, 12'd21, 1'b0, 1'b0, 2'd0, 2'd1, "R6");
    // ages 1=0,3=1,0=2,2=3. Flag way 3 then way 0 by hits
    send(4'd3, 12'd11, 1'b1, 1'b1, 2'd3, 2'd0, "R8"); // ages 3=0,1=1,0=2,2=3
    send(4'd3, 12'd10, 1'b1, 1'b1, 2'd0, 2'd0, "R8"); // ages 0=0,3=1,1=2,2=3
    // flagged ways 0 (age0) and 3 (age1): older flagged way 3 (R7)
    send(4'd3, 12'd22, 1'b0, 1'b0, 2'd0, 2'd3, "R7"); // ages 3=0,0=1,1=2,2=3
    // remaining flag is way 0; clear it by hit with hint 0 (R8)
    send(4'd3, 12'd10, 1'b0, 1'b1, 2'd0, 2'd0, "R8"); // ages 0=0,3=1,1=2,2=3
    send(4'd3, 12'd23, 1'b0, 1'b0, 2'd0, 2'd2, "R8"); // no flags left: LRU way 2
    // ages 2=0,0=1,3=2,1=3. Fill with hint 1 (R9) into LRU way 1
    send(4'd3, 12'd24, 1'b1, 1'b0, 2'd0, 2'd1, "R9"); // ages 1=0,2=1,0=2,3=3
    // the fill stored the flag: newest line way 1 is evicted next (R9)
    send(4'd3, 12'd25, 1'b0, 1'b0, 2'd0, 2'd1, "R9"); // ages 1=0,2=1,0=2,3=3

    // Other set is untouched by set 3 history (R10)
    send(4'd5, 12'd10, 1'b0, 1'b0, 2'd0, 2'd0, "R10");
    send(4'd5, 12'd25, 1'b0, 1'b0, 2'd0, 2'd1, "R10");
    send(4'd3, 12'd25, 1'b0, 1'b1, 2'd1, 2'd0, "R10"); // ages 1=0,2=1,0=2,3=3

    // Idle cycles with junk inputs change nothing (R11)
    idle_check("R11");
    send(4'd3, 12'd26, 1'b0, 1'b0, 2'd0, 2'd3, "R11"); // LRU still way 3
    send(4'd3, 12'd23, 1'b0, 1'b1, 2'd2, 2'd0, "R11");
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule